// File: doc/BRIEF.md
# Error Interrupt Aggregator

This block gathers error events from a set of leaf collectors and turns them into one interrupt request for a downstream message generator. Each leaf keeps a sticky record of the error events it has seen and an enable mask. Only recorded errors whose enable bit is set reach the central stage. The central stage ORs the enabled errors of all leaves together.

The central stage holds an arm flag and an interrupt vector, both set by software. When the flag is set and any enabled error is recorded, it raises a request that carries the programmed vector. The request stays up until the downstream side acknowledges it. Acceptance clears the arm flag, so software must set it again before any further error interrupt. The vector always names a message-table entry directly; no ring or indirection is involved.

Software reaches every register through a plain single-cycle write port and a combinational read port. Status bits are cleared by writing 1 to them. The register layout, with NUM_LEAF=4, is: status of leaf i at address i (bits [LEAF_W-1:0]), mask of leaf i at address NUM_LEAF+i, control at address 2*NUM_LEAF (bit 0 arm, bits [16+VEC_W-1:16] vector), and a read-only summary at address 2*NUM_LEAF+1 (bit i set when leaf i has an enabled recorded error). All other addresses and bits read as zero.

Top module: `err_aggregator`

## Requirements
- R1: After reset every status, mask, arm flag and vector reads as zero, and irq_req and irq_vec are low.
- R2: A high bit of err_in sets the matching status bit at the next clock edge; the bit stays set until software writes 1 to it at that leaf's status address, and an error arriving in the same cycle as that clear leaves the bit set.
- R3: A write to a status address clears exactly the bits written as 1 and leaves the bits written as 0 unchanged.
- R4: A mask write replaces that leaf's mask; a recorded error appears in the summary register (bit i for leaf i) and can cause an interrupt only while its mask bit is 1, and masked errors are still recorded in status.
- R5: irq_req rises at the clock edge after one in which the arm flag is 1, irq_req is low and any leaf has an enabled recorded error; it never rises while the arm flag is 0.
- R6: While irq_req is high and irq_ack is low, irq_req stays high and irq_vec stays equal to the vector held in the control register at the moment the request rose, even if software rewrites the vector.
- R7: A cycle with irq_req and irq_ack both high drops irq_req and clears the arm flag at that edge; errors then stay pending without a request until software sets the arm flag again. A control write in that same cycle sets the arm flag to the written value.
- R8: An enabled error in any one of the leaves is enough to raise the request.
- R9: Control bit 0 reads back the current arm flag, including its clearing by hardware, and bits [16+VEC_W-1:16] read back the programmed vector; writes to the summary address and to unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | NUM_LEAF*LEAF_W | Error event pulses, leaf i on bits [i*LEAF_W +: LEAF_W] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_req | output | 1 | Error interrupt request, held until acknowledged |
| irq_vec | output | VEC_W | Message-table index carried by the request |
| irq_ack | input | 1 | Downstream acceptance of the request |

## Verification
The hardest situation to reach is the acceptance edge meeting a software re-arm in the same cycle while an error is still pending, since it needs the acknowledge, a control write and a held status bit lined up at once. The bench builds that case directly: it leaves an enabled error recorded, raises a request, then drives irq_ack and the control write together and watches the request fall and rise again one edge later. A long phase of sparse random errors, mask and clear writes, re-arms and acknowledges then compares every output against a behavioural model on every clock, which also catches clears that coincide with new errors.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
   // Control register field positions (software-visible layout)
   localparam int CTRL_ARM_BIT = 0;
   localparam int CTRL_VEC_LSB = 16;

   function automatic int addr_bits_needed(input int num_leaf);
      return $clog2(2 * num_leaf + 2);
   endfunction
endpackage

// File: rtl/err_leaf.sv
module err_leaf #(
   parameter int LEAF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEAF_W-1:0] err_ev,
   input  logic              sts_w1c,
   input  logic              msk_wr,
   input  logic [LEAF_W-1:0] wdata,
   output logic [LEAF_W-1:0] sts_o,
   output logic [LEAF_W-1:0] msk_o,
   output logic              hit_o
);
   logic [LEAF_W-1:0] sts_q, msk_q, clr_bits;

   assign clr_bits = sts_w1c ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q <= '0;
         msk_q <= '0;
      end else begin
         sts_q <= (sts_q & ~clr_bits) | err_ev;
         if (msk_wr) msk_q <= wdata;
      end
   end

   assign sts_o = sts_q;
   assign msk_o = msk_q;
   assign hit_o = |(sts_q & msk_q);

   // Recorded bits survive any cycle without a clear
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_w1c |=> ((sts_q & $past(sts_q)) == $past(sts_q))) else $error("sticky"); // R2
   // A fully masked leaf never reports upward
   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q == '0) |-> !hit_o) else $error("masked"); // R4
endmodule

// File: rtl/err_central.sv
module err_central #(
   parameter int NUM_LEAF = 4,
   parameter int VEC_W    = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_LEAF-1:0] leaf_hit,
   input  logic                ctrl_wr,
   input  logic                wr_arm,
   input  logic [VEC_W-1:0]    wr_vec,
   input  logic                irq_ack,
   output logic                arm_o,
   output logic [VEC_W-1:0]    vec_o,
   output logic                irq_req,
   output logic [VEC_W-1:0]    irq_vec
);
   logic             arm_q, req_q, any_err;
   logic [VEC_W-1:0] vec_q, qvec_q;

   assign any_err = |leaf_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         req_q  <= 1'b0;
         vec_q  <= '0;
         qvec_q <= '0;
      end else begin
         if (req_q && irq_ack) begin
            req_q <= 1'b0;
            arm_q <= 1'b0;
         end else if (!req_q && arm_q && any_err) begin
            req_q  <= 1'b1;
            qvec_q <= vec_q;
         end
         // A software write in the same cycle overrides the hardware clear
         if (ctrl_wr) begin
            arm_q <= wr_arm;
            vec_q <= wr_vec;
         end
      end
   end

   assign arm_o   = arm_q;
   assign vec_o   = vec_q;
   assign irq_req = req_q;
   assign irq_vec = qvec_q;

   AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(arm_q)) else $error("unarmed request"); // R5
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !irq_ack) |=> (req_q && $stable(qvec_q))) else $error("hold"); // R6
   AST_ACK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && irq_ack && !ctrl_wr) |=> (!arm_q && !req_q)) else $error("disarm"); // R7
endmodule

// File: rtl/err_aggregator.sv
module err_aggregator
   import err_agg_pkg::*;
#(
   parameter int NUM_LEAF = 4,
   parameter int LEAF_W   = 8,
   parameter int VEC_W    = 11,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_LEAF*LEAF_W-1:0] err_in,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic                       irq_req,
   output logic [VEC_W-1:0]           irq_vec,
   input  logic                       irq_ack
);
   localparam int CTRL_ADDR = 2 * NUM_LEAF;
   localparam int SUM_ADDR  = 2 * NUM_LEAF + 1;

   // Elaboration-time parameter checks
   if (NUM_LEAF < 1)                      begin : g_bad_leaf  $error("NUM_LEAF must be at least 1"); end
   if (LEAF_W > DATA_W)                   begin : g_bad_lw    $error("LEAF_W exceeds DATA_W"); end
   if (NUM_LEAF > DATA_W)                 begin : g_bad_sum   $error("summary does not fit DATA_W"); end
   if (CTRL_VEC_LSB + VEC_W > DATA_W)     begin : g_bad_vec   $error("vector does not fit DATA_W"); end
   if (ADDR_W < addr_bits_needed(NUM_LEAF)) begin : g_bad_addr $error("ADDR_W too small"); end

   logic [LEAF_W-1:0] sts_a [NUM_LEAF];
   logic [LEAF_W-1:0] msk_a [NUM_LEAF];
   logic [NUM_LEAF-1:0] hit;
   logic             arm;
   logic [VEC_W-1:0] vec;
   logic             ctrl_wr;
   logic             unused_wdata_bits;

   assign ctrl_wr           = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign unused_wdata_bits = ^bus_wdata;

   for (genvar i = 0; i < NUM_LEAF; i++) begin : g_leaf
      err_leaf #(.LEAF_W(LEAF_W)) u_leaf (
         .clk     (clk),
         .rst_n   (rst_n),
         .err_ev  (err_in[i*LEAF_W +: LEAF_W]),
         .sts_w1c (bus_wr && (bus_addr == ADDR_W'(i))),
         .msk_wr  (bus_wr && (bus_addr == ADDR_W'(NUM_LEAF + i))),
         .wdata   (bus_wdata[LEAF_W-1:0]),
         .sts_o   (sts_a[i]),
         .msk_o   (msk_a[i]),
         .hit_o   (hit[i])
      );
   end

   err_central #(.NUM_LEAF(NUM_LEAF), .VEC_W(VEC_W)) u_central (
      .clk      (clk),
      .rst_n    (rst_n),
      .leaf_hit (hit),
      .ctrl_wr  (ctrl_wr),
      .wr_arm   (bus_wdata[CTRL_ARM_BIT]),
      .wr_vec   (bus_wdata[CTRL_VEC_LSB +: VEC_W]),
      .irq_ack  (irq_ack),
      .arm_o    (arm),
      .vec_o    (vec),
      .irq_req  (irq_req),
      .irq_vec  (irq_vec)
   );

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_LEAF; i++) begin
         if (bus_addr == ADDR_W'(i))            bus_rdata[LEAF_W-1:0] = sts_a[i];
         if (bus_addr == ADDR_W'(NUM_LEAF + i)) bus_rdata[LEAF_W-1:0] = msk_a[i];
      end
      if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
         bus_rdata[CTRL_ARM_BIT]              = arm;
         bus_rdata[CTRL_VEC_LSB +: VEC_W]     = vec;
      end
      if (bus_addr == ADDR_W'(SUM_ADDR)) bus_rdata[NUM_LEAF-1:0] = hit;
   end

   // Out of reset nothing is requested (R1)
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !irq_req) else $error("reset"); // R1
endmodule

// File: tb/err_aggregator_tb.sv
`timescale 1ns/1ps
module err_aggregator_tb;
   localparam int NL = 4, LW = 8, VW = 11, AW = 4, DW = 32;
   localparam int CTRL_A = 2*NL, SUM_A = 2*NL+1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NL*LW-1:0] err_in = '0;
   logic bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic irq_req, irq_ack = 1'b0;
   logic [VW-1:0] irq_vec;

   int errors = 0, checks = 0;
   bit done = 1'b0;
   string phase = "R1";

   always #5 clk = ~clk;

   err_aggregator #(.NUM_LEAF(NL), .LEAF_W(LW), .VEC_W(VW), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .err_in(err_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
      .irq_ack(irq_ack));

   // Behavioural reference model
   logic [LW-1:0] m_sts [NL];
   logic [LW-1:0] m_msk [NL];
   bit m_arm, m_req;
   logic [VW-1:0] m_vec, m_qvec;

   function automatic bit m_any();
      for (int i = 0; i < NL; i++) if ((m_sts[i] & m_msk[i]) != 0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [DW-1:0] m_rd(input logic [AW-1:0] a);
      logic [DW-1:0] r = '0;
      if (int'(a) < NL) r[LW-1:0] = m_sts[a];
      else if (int'(a) < 2*NL) r[LW-1:0] = m_msk[int'(a)-NL];
      else if (int'(a) == CTRL_A) r = {5'd0, m_vec, 15'd0, m_arm};
      else if (int'(a) == SUM_A)
         for (int i = 0; i < NL; i++) r[i] = ((m_sts[i] & m_msk[i]) != 0);
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NL; i++) begin m_sts[i] = '0; m_msk[i] = '0; end
         m_arm = 0; m_req = 0; m_vec = '0; m_qvec = '0;
      end else begin
         bit hit;
         hit = m_any();
         if (m_req && irq_ack) begin m_req = 0; m_arm = 0; end
         else if (!m_req && m_arm && hit) begin m_req = 1; m_qvec = m_vec; end
         if (bus_wr && int'(bus_addr) == CTRL_A) begin
            m_arm = bus_wdata[0]; m_vec = bus_wdata[16 +: VW];
         end
         for (int i = 0; i < NL; i++) begin
            if (bus_wr && int'(bus_addr) == i) m_sts[i] = m_sts[i] & ~bus_wdata[LW-1:0];
            m_sts[i] = m_sts[i] | err_in[i*LW +: LW];
            if (bus_wr && int'(bus_addr) == NL+i) m_msk[i] = bus_wdata[LW-1:0];
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Every-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(phase, "irq_req", DW'(irq_req), DW'(m_req));
         chk(phase, "irq_vec", DW'(irq_vec), DW'(m_qvec));
         chk(phase, "bus_rdata", bus_rdata, m_rd(bus_addr));
      end
   end

   task automatic tick(); @(posedge clk); #1; endtask
   task automatic wr(input int a, input logic [DW-1:0] d);
      bus_wr = 1; bus_addr = AW'(a); bus_wdata = d; tick(); bus_wr = 0;
   endtask
   task automatic pulse(input logic [NL*LW-1:0] e);
      err_in = e; tick(); err_in = '0;
   endtask
   task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
      bus_addr = AW'(a); #1; chk(req, $sformatf("read addr %0d", a), bus_rdata, exp);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      phase = "R1";
      for (int a = 0; a <= SUM_A; a++) rd_chk("R1", a, '0);
      chk("R1", "irq_req after reset", DW'(irq_req), 0);
      // R2 / R4: masked error is recorded but not summarised
      phase = "R2";
      pulse(32'h0000_0004);
      rd_chk("R2", 0, 32'h4);
      rd_chk("R4", SUM_A, 0);
      phase = "R4";
      wr(4, 32'hFF);
      rd_chk("R4", SUM_A, 32'h1);
      chk("R5", "no request while disarmed", DW'(irq_req), 0);
      // R5: arm with vector 0x155
      phase = "R5";
      wr(CTRL_A, (32'h155 << 16) | 1);
      chk("R5", "request not yet up", DW'(irq_req), 0);
      tick();
      chk("R5", "request up", DW'(irq_req), 1);
      chk("R5", "vector", DW'(irq_vec), 32'h155);
      // R6: rewrite vector while pending
      phase = "R6";
      wr(CTRL_A, (32'h2AA << 16) | 1);
      tick();
      chk("R6", "request held", DW'(irq_req), 1);
      chk("R6", "vector held", DW'(irq_vec), 32'h155);
      // R7: acceptance disarms
      phase = "R7";
      irq_ack = 1; tick(); irq_ack = 0;
      chk("R7", "request dropped", DW'(irq_req), 0);
      rd_chk("R9", CTRL_A, 32'h02AA_0000);
      tick(); tick();
      chk("R7", "no refire while disarmed", DW'(irq_req), 0);
      // R3 / R2 corner: partial clear and clear colliding with a new error
      phase = "R3";
      pulse(32'h0000_0003);
      rd_chk("R3", 0, 32'h7);
      wr(0, 32'h2);
      rd_chk("R3", 0, 32'h5);
      phase = "R2";
      bus_wr = 1; bus_addr = 0; bus_wdata = 32'h1; err_in = 32'h1; tick();
      bus_wr = 0; err_in = '0;
      rd_chk("R2", 0, 32'h5);
      wr(0, 32'hFF);
      rd_chk("R2", 0, 32'h0);
      // R9: writes to summary and unused addresses change nothing
      phase = "R9";
      wr(SUM_A, 32'hFFFF_FFFF);
      wr(12, 32'hFFFF_FFFF);
      rd_chk("R9", SUM_A, 0);
      rd_chk("R9", CTRL_A, 32'h02AA_0000);
      // R8: leaf 3 alone raises the request
      phase = "R8";
      wr(CTRL_A, 32'h0000_0001);
      tick();
      chk("R5", "armed but nothing pending", DW'(irq_req), 0);
      wr(7, 32'h80);
      pulse(32'h8000_0000);
      rd_chk("R8", SUM_A, 32'h8);
      tick();
      chk("R8", "leaf 3 request", DW'(irq_req), 1);
      chk("R8", "vector zero", DW'(irq_vec), 0);
      // R7: acceptance and re-arm in the same cycle
      phase = "R7";
      irq_ack = 1; bus_wr = 1; bus_addr = AW'(CTRL_A); bus_wdata = (32'h3 << 16) | 1; tick();
      irq_ack = 0; bus_wr = 0;
      chk("R7", "dropped on collision", DW'(irq_req), 0);
      rd_chk("R7", CTRL_A, 32'h0003_0001);
      tick();
      chk("R7", "refire after re-arm", DW'(irq_req), 1);
      chk("R7", "new vector", DW'(irq_vec), 32'h3);
      irq_ack = 1; tick(); irq_ack = 0;
      // Random phase, model compared every clock
      phase = "R2-random/R5/R6/R7";
      for (int n = 0; n < 4000; n++) begin
         err_in = ($urandom_range(0, 9) == 0) ? (32'h1 << $urandom_range(0, 31)) : '0;
         irq_ack = ($urandom_range(0, 3) == 0);
         bus_wr = ($urandom_range(0, 4) == 0);
         bus_addr = AW'($urandom_range(0, 15));
         bus_wdata = $urandom();
         if (bus_wr && int'(bus_addr) < NL) bus_wdata = 32'(1 << $urandom_range(0, 7));
         tick();
      end
      bus_wr = 0; err_in = '0; irq_ack = 0;
      tick();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule